// File: doc/BRIEF.md
# Bit-Sliced Two-Level Decoded Static Memory

A synchronous 32K x 8 static memory. Storage is not one flat word array: it is eight independent bit-slices, each holding 512 rows of 64 bits. One slice holds one bit position of every stored byte. A single row decoder, shared by all slices, turns the upper nine address bits into a one-hot row line. In each slice a 64-to-1 column multiplexer, driven by the lower six address bits, picks one bit out of the selected row.

Accesses are gated by chip select. A write needs chip select and write enable. A read needs chip select and output enable, and it returns data one cycle after the address is presented. When no read is granted, the output byte is driven to zero and a valid flag stays low. This flag and the zero byte stand in for a high-impedance output.

Top module: `sram_sliced_32kx8`

## Requirements
- R1: While reset is asserted and after it is released with no access, `valid_o` is low and `rdata_o` is zero.
- R2: With `cs_i` and `we_i` high at a rising edge, `wdata_i` is stored at `addr_i` and is returned by later reads of that address.
- R3: With `cs_i` and `oe_i` high at a rising edge, `valid_o` is high after that edge and `rdata_o` holds the byte stored at `addr_i`.
- R4: When `cs_i` or `oe_i` is low at a rising edge, `valid_o` is low and `rdata_o` is 8'h00 after that edge.
- R5: With `cs_i` low, `we_i` has no effect: the addressed byte keeps its earlier value.
- R6: A read and a write to the same address in one cycle return the value held before the write, and the new value is stored.
- R7: Address bits [14:6] pick the row and bits [5:0] pick the column. Bit k of a byte lives in slice k. Addresses that differ only in row or only in column are independent locations.
- R8: A write proceeds regardless of `oe_i`. A write with `oe_i` low stores data and leaves `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the read path |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | Write enable |
| oe_i | input | 1 | Output enable |
| addr_i | input | 15 | Byte address: [14:6] row, [5:0] column |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, zero when not valid |
| valid_o | output | 1 | Read data valid, stands in for a driven bus |

## Verification
A read and a write can be granted in the same cycle, and they can hit the same bit cells. The bench asserts chip select, write enable and output enable together on one address. It does this on purpose in directed steps, and it also happens in the random traffic. It expects the byte from before the write on the output, then reads the address again and expects the new byte. A flat reference array of bytes, updated only after each expected read value has been taken, judges both outcomes.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ROW_W  = 9;
  localparam int unsigned COL_W  = 6;
  localparam int unsigned ADDR_W = ROW_W + COL_W;
endpackage

// File: rtl/sram_row_decoder.sv
module sram_row_decoder #(
  parameter int unsigned ROW_W = sram_pkg::ROW_W,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic             en_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROWS-1:0]  row_hot_o
);
  always_comb begin
    row_hot_o = '0;
    if (en_i) row_hot_o[row_i] = 1'b1;
  end

  // R7: exactly one word line active when enabled, none otherwise
  always_comb begin
    if (en_i) a_r7_row_onehot: assert ($countones(row_hot_o) == 1);
    else      a_r7_row_idle:   assert (row_hot_o == '0);
  end
endmodule

// File: rtl/sram_col_mux.sv
module sram_col_mux #(
  parameter int unsigned COL_W = sram_pkg::COL_W,
  localparam int unsigned COLS = 1 << COL_W
) (
  input  logic [COLS-1:0]  row_bits_i,
  input  logic [COL_W-1:0] col_i,
  output logic             bit_o
);
  assign bit_o = row_bits_i[col_i];
endmodule

// File: rtl/sram_bit_slice.sv
module sram_bit_slice #(
  parameter int unsigned ROW_W = sram_pkg::ROW_W,
  parameter int unsigned COL_W = sram_pkg::COL_W,
  localparam int unsigned ROWS = 1 << ROW_W,
  localparam int unsigned COLS = 1 << COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROWS-1:0]  row_hot_i,
  input  logic [ROW_W-1:0] row_idx_i,  // checking only
  input  logic [COL_W-1:0] col_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             wbit_i,
  output logic             rbit_o
);
  logic [COLS-1:0] mem [ROWS];
  logic [COLS-1:0] row_bits;
  logic            col_bit;
  logic            rbit_q;

  // word line gated onto shared bit lines
  always_comb begin
    row_bits = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_hot_i[r]) row_bits = row_bits | mem[r];
  end

  sram_col_mux #(.COL_W(COL_W)) u_col_mux (
    .row_bits_i (row_bits),
    .col_i      (col_i),
    .bit_o      (col_bit)
  );

  always_ff @(posedge clk_i) begin
    for (int r = 0; r < ROWS; r++)
      if (wr_i && row_hot_i[r]) mem[r][col_i] <= wbit_i;
  end

  // samples pre-write contents: read-before-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rbit_q <= 1'b0;
    else if (rd_i) rbit_q <= col_bit;
  end

  assign rbit_o = rbit_q;

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem[$past(row_idx_i)][$past(col_i)] == $past(wbit_i));
endmodule

// File: rtl/sram_sliced_32kx8.sv
module sram_sliced_32kx8 #(
  parameter int unsigned DATA_W = sram_pkg::DATA_W,
  parameter int unsigned ROW_W  = sram_pkg::ROW_W,
  parameter int unsigned COL_W  = sram_pkg::COL_W,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned ROWS   = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [ROWS-1:0]   row_hot;
  logic [DATA_W-1:0] rbits;
  logic              wr, rd, valid_q;

  assign row = addr_i[ADDR_W-1:COL_W];
  assign col = addr_i[COL_W-1:0];
  assign wr  = cs_i & we_i;
  assign rd  = cs_i & oe_i;

  sram_row_decoder #(.ROW_W(ROW_W)) u_row_dec (
    .en_i      (cs_i),
    .row_i     (row),
    .row_hot_o (row_hot)
  );

  for (genvar k = 0; k < DATA_W; k++) begin : g_slice
    sram_bit_slice #(.ROW_W(ROW_W), .COL_W(COL_W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .row_hot_i (row_hot),
      .row_idx_i (row),
      .col_i     (col),
      .wr_i      (wr),
      .rd_i      (rd),
      .wbit_i    (wdata_i[k]),
      .rbit_o    (rbits[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= rd;
  end

  assign valid_o = valid_q;
  assign rdata_o = rbits & {DATA_W{valid_q}};

  a_r3_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && oe_i) |=> valid_o);
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && oe_i) |=> (!valid_o && rdata_o == '0));
endmodule

// File: tb/sram_sliced_32kx8_test.sv
`timescale 1ns/1ps
module sram_sliced_32kx8_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs = 1'b0, we = 1'b0, oe = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        valid;
  int          n_checks = 0;
  int          n_fail = 0;
  logic [7:0]  ref_mem [int];
  logic [14:0] pool [16];

  always #2.5 clk = ~clk;

  sram_sliced_32kx8 uut (
    .clk_i (clk), .rst_ni (rst_ni), .cs_i (cs), .we_i (we), .oe_i (oe),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .valid_o (valid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic c, input logic w, input logic o,
                        input logic [14:0] a, input logic [7:0] d, input string req);
    logic exp_v;
    @(negedge clk);
    cs = c; we = w; oe = o; addr = a; wdata = d;
    @(posedge clk); #1;
    exp_v = c && o;
    check(exp_v ? "R3" : "R4", {7'd0, valid}, {7'd0, exp_v});
    if (!exp_v) check("R4", rdata, 8'h00);
    else if (ref_mem.exists(int'(a))) check(req, rdata, ref_mem[int'(a)]);
    if (c && w) ref_mem[int'(a)] = d;
  endtask

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {7'd0, valid}, 8'h00);
    check("R1", rdata, 8'h00);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1", {7'd0, valid}, 8'h00);

    access(1, 1, 0, 15'h0000, 8'hA5, "R2");
    access(1, 0, 1, 15'h0000, 8'h00, "R2");
    access(1, 1, 0, 15'h7FFF, 8'h3C, "R2");
    access(1, 0, 1, 15'h7FFF, 8'h00, "R3");
    // R7: column and row neighbours stay independent
    access(1, 1, 0, 15'h0001, 8'h0F, "R7");
    access(1, 1, 0, 15'h0040, 8'hF0, "R7");
    access(1, 0, 1, 15'h0000, 8'h00, "R7");
    access(1, 0, 1, 15'h0001, 8'h00, "R7");
    access(1, 0, 1, 15'h0040, 8'h00, "R7");
    // R5: write attempt without chip select
    access(0, 1, 1, 15'h0000, 8'hFF, "R5");
    access(1, 0, 1, 15'h0000, 8'h00, "R5");
    // R8: write with output enable low
    access(1, 1, 0, 15'h0001, 8'h55, "R8");
    access(1, 0, 1, 15'h0001, 8'h00, "R8");
    // R6: same-cycle read and write
    access(1, 1, 1, 15'h0000, 8'h77, "R6");
    access(1, 0, 1, 15'h0000, 8'h00, "R6");
    access(1, 0, 0, 15'h0000, 8'h00, "R4");

    for (int i = 0; i < 16; i++)
      pool[i] = (i < 8) ? {6'd0, 3'(i), 6'($urandom)} : 15'($urandom);
    for (int i = 0; i < 16; i++) access(1, 1, 0, pool[i], 8'($urandom), "R2");
    for (int i = 0; i < 600; i++) begin
      logic c, w, o;
      c = ($urandom % 8) != 0;
      w = $urandom[0];
      o = $urandom[0];
      access(c, w, o, pool[$urandom % 16], 8'($urandom), (c && w && o) ? "R6" : "R3");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule